// File: doc/BRIEF.md
# External Interrupt Enable and Priority Unit

This unit receives up to 32 level-sensitive external interrupt lines. It gives software three machine-mode CSRs for them: a per-line enable mask that can be read and written, a read-only view of the line levels after synchronization, and a read-only index of the winning line. The unit ANDs the synchronized levels with the enable mask. From that product it makes two things: a single external-pending flag that feeds the standard interrupt-pending logic, and the position of the lowest-numbered active line, which a trap handler or vectoring logic can use directly.

The global machine interrupt enable and the external interrupt enable are kept elsewhere and arrive as plain inputs. The unit combines them with its filtered flag into a take request. An interrupt line stays pending for as long as its source holds it high. Only servicing the source clears it.

Top module: `irq_unit`

## Requirements
- R1: After reset, the enable CSR (address 0xBE0) reads 0xFFFFFFFF. The pending CSR (0xFE0) and the lowest-index CSR (0xFE4) read 0. `extPending`, `irqTake` and `lowestIdx` are 0.
- R2: A cycle with `csrWrEn` high and `csrAddr` equal to 0xBE0 loads all 32 bits of `csrWrData` into the enable CSR at that clock edge. A read of 0xBE0 in the same cycle still returns the value held before the edge.
- R3: Bit i of the pending CSR equals the level `irqIn[i]` had two rising edges earlier: one synchronizer flop, then the pending flop. It falls in the same way once the source drops.
- R4: `extPending` is 1 exactly when at least one bit is set in both the pending CSR and the enable CSR.
- R5: The lowest-index CSR bits 4:0, and the `lowestIdx` port, hold the position of the least-significant bit set in (pending AND enable). CSR bits 31:5 read 0.
- R6: When no bit is set in both pending and enable, the lowest index is 0.
- R7: `irqTake` is 1 only when `extPending`, `globalIe` and `extIe` are all 1.
- R8: A read of any address other than 0xBE0, 0xFE0 and 0xFE4 returns 0. This includes the reserved bank addresses 0xBE1–0xBE3 and 0xFE1–0xFE3.
- R9: A write to 0xFE0, 0xFE4, a reserved address or an unmapped address leaves the enable CSR unchanged.
- R10: A write to the pending CSR address does not change the pending CSR, which keeps following the synchronized inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqIn | input | 32 | Raw level-sensitive interrupt lines |
| csrAddr | input | 12 | CSR address for read and write |
| csrWrEn | input | 1 | CSR write strobe |
| csrWrData | input | 32 | CSR write data |
| csrRdData | output | 32 | CSR read data, combinational from `csrAddr` |
| globalIe | input | 1 | Global machine interrupt enable |
| extIe | input | 1 | Machine external interrupt enable |
| extPending | output | 1 | Filtered external-pending flag |
| lowestIdx | output | 5 | Lowest active line index |
| irqTake | output | 1 | Interrupt take request |

## Verification
Two updates can land on the same clock edge: a software write to the enable mask, and a change in a synchronized line level. The bench makes them coincide. It raises a line two cycles ahead so that its pending flop loads on exactly the edge where a new mask is written. Before that edge it checks that a read of the mask returns the old value. After the edge it checks that the flag and the winning index both reflect the new mask together with the new level. A table of mask and line patterns, judged against an independent priority model, covers the remaining combinations.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Decoded CSR access strobes, passed from the control to the datapath.
  typedef struct packed {
    logic selEnable;
    logic selPending;
    logic selLowest;
    logic wrEnable;
  } csrStrobe_t;

endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] ENABLE_ADDR  = 12'hBE0,
  parameter logic [ADDR_W-1:0] PENDING_ADDR = 12'hFE0,
  parameter logic [ADDR_W-1:0] LOWEST_ADDR  = 12'hFE4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              csrWrEn,
  input  logic              globalIe,
  input  logic              extIe,
  input  logic              extPending,
  output csrStrobe_t        strb,
  output logic              irqTake
);

  // Address decode. Reserved and unmapped addresses select nothing,
  // so reads there return zero and writes there are dropped.
  always_comb begin
    strb            = '0;
    strb.selEnable  = (csrAddr == ENABLE_ADDR);
    strb.selPending = (csrAddr == PENDING_ADDR);
    strb.selLowest  = (csrAddr == LOWEST_ADDR);
    // Only the enable CSR accepts writes.
    strb.wrEnable   = csrWrEn && strb.selEnable;
  end

  // Take request: filtered flag gated by both global enables.
  assign irqTake = extPending && globalIe && extIe;

  // R8: at most one CSR is selected at a time.
  p_sel_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selEnable, strb.selPending, strb.selLowest}));

  // R9: a write strobe reaches the datapath only for the enable CSR.
  p_wr_only_enable_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEnable |-> (csrAddr == ENABLE_ADDR));

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_IRQ     = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  csrStrobe_t         strb,
  input  logic [DATA_W-1:0]  csrWrData,
  output logic [DATA_W-1:0]  csrRdData,
  output logic               extPending,
  output logic [IDX_W-1:0]   lowestIdx
);

  logic [NUM_IRQ-1:0] syncQ [SYNC_STAGES];
  logic [NUM_IRQ-1:0] pendQ;
  logic [NUM_IRQ-1:0] enQ;
  logic [NUM_IRQ-1:0] activeVec;

  // Synchronizer chain. Its last stage is the pending register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= irqIn;
  end

  for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[k] <= '0;
      else       syncQ[k] <= syncQ[k-1];
    end
  end

  assign pendQ = syncQ[SYNC_STAGES-1];

  // Enable bank: resets to all ones, so software that only uses the
  // global enables still sees every line.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             enQ <= '1;
    else if (strb.wrEnable) enQ <= csrWrData[NUM_IRQ-1:0];
  end

  assign activeVec  = pendQ & enQ;
  assign extPending = |activeVec;

  // LSB-first priority encode of the active lines.
  always_comb begin
    logic found;
    found     = 1'b0;
    lowestIdx = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (!found && activeVec[i]) begin
        lowestIdx = IDX_W'(i);
        found     = 1'b1;
      end
    end
  end

  // Read mux. Unselected addresses read zero.
  always_comb begin
    csrRdData = '0;
    if (strb.selEnable)       csrRdData[NUM_IRQ-1:0] = enQ;
    else if (strb.selPending) csrRdData[NUM_IRQ-1:0] = pendQ;
    else if (strb.selLowest)  csrRdData[IDX_W-1:0]   = lowestIdx;
  end

  // R2: a write strobe lands its data in the enable bank at the edge.
  p_en_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEnable |=> (enQ == $past(csrWrData[NUM_IRQ-1:0])));

  // R9: without a write strobe, the enable bank holds its value.
  p_en_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEnable |=> $stable(enQ));

  // R5: when the flag is up, the reported index is a pending, enabled line.
  p_winner_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    extPending |-> (pendQ[lowestIdx] && enQ[lowestIdx]));

  // R6: with nothing active, the index is zero.
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !extPending |-> (lowestIdx == '0));

endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import irq_pkg::*;
#(
  parameter int NUM_IRQ     = 32,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic [ADDR_W-1:0]  csrAddr,
  input  logic               csrWrEn,
  input  logic [DATA_W-1:0]  csrWrData,
  output logic [DATA_W-1:0]  csrRdData,
  input  logic               globalIe,
  input  logic               extIe,
  output logic               extPending,
  output logic [IDX_W-1:0]   lowestIdx,
  output logic               irqTake
);

  csrStrobe_t strb;

  irq_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .csrAddr    (csrAddr),
    .csrWrEn    (csrWrEn),
    .globalIe   (globalIe),
    .extIe      (extIe),
    .extPending (extPending),
    .strb       (strb),
    .irqTake    (irqTake)
  );

  irq_datapath #(
    .NUM_IRQ     (NUM_IRQ),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .irqIn      (irqIn),
    .strb       (strb),
    .csrWrData  (csrWrData),
    .csrRdData  (csrRdData),
    .extPending (extPending),
    .lowestIdx  (lowestIdx)
  );

  // R7: a take request never appears without the filtered flag.
  p_take_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqTake |-> extPending);

endmodule

// File: tb/irq_unit_tb.sv
module irq_unit_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] irqIn;
  logic [11:0] csrAddr;
  logic        csrWrEn;
  logic [31:0] csrWrData;
  logic [31:0] csrRdData;
  logic        globalIe;
  logic        extIe;
  logic        extPending;
  logic [4:0]  lowestIdx;
  logic        irqTake;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  irq_unit u_dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .csrAddr(csrAddr),
    .csrWrEn(csrWrEn), .csrWrData(csrWrData), .csrRdData(csrRdData),
    .globalIe(globalIe), .extIe(extIe), .extPending(extPending),
    .lowestIdx(lowestIdx), .irqTake(irqTake)
  );

  // Each entry holds {line levels, enable mask}.
  localparam logic [63:0] VEC [10] = '{
    {32'h0000_0001, 32'hFFFF_FFFF},
    {32'h8000_0000, 32'hFFFF_FFFF},
    {32'h8000_0010, 32'hFFFF_FFEF},
    {32'h00F0_0000, 32'h00C0_0000},
    {32'h1234_5678, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'h8000_0000},
    {32'h0000_0006, 32'h0000_0006},
    {32'h0000_0000, 32'hFFFF_FFFF},
    {32'hAAAA_AAAA, 32'h5555_5554},
    {32'h0001_0100, 32'hFFFF_FEFF}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rdCsr(logic [11:0] a, output logic [31:0] d);
    csrAddr = a;
    #1;
    d = csrRdData;
  endtask

  function automatic logic [4:0] lowModel(logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return 5'(i);
    return 5'd0;
  endfunction

  // Drive a mask write and line levels, then wait two edges.
  task automatic apply(logic [31:0] lines, logic [31:0] mask);
    @(negedge clk);
    irqIn = lines; csrAddr = 12'hBE0; csrWrEn = 1'b1; csrWrData = mask;
    @(negedge clk);
    csrWrEn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] act;
    irqIn = '0; csrAddr = '0; csrWrEn = 1'b0; csrWrData = '0;
    globalIe = 1'b1; extIe = 1'b1; rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdCsr(12'hBE0, d); chk("R1 enable", d, 32'hFFFF_FFFF);
    rdCsr(12'hFE0, d); chk("R1 pending", d, 32'h0);
    rdCsr(12'hFE4, d); chk("R1 lowest", d, 32'h0);
    chk("R1 flags", {29'h0, extPending, irqTake, |lowestIdx}, 32'h0);

    // Table walk, R2 R3 R4 R5 R6 R7
    foreach (VEC[n]) begin
      logic [31:0] ln, mk, act2;
      ln = VEC[n][63:32]; mk = VEC[n][31:0]; act2 = ln & mk;
      apply(ln, mk);
      rdCsr(12'hBE0, d); chk("R2 enable readback", d, mk);
      rdCsr(12'hFE0, d); chk("R3 pending", d, ln);
      rdCsr(12'hFE4, d); chk("R5 lowest csr", d, {27'h0, lowModel(act2)});
      chk("R5 lowestIdx port", {27'h0, lowestIdx}, {27'h0, lowModel(act2)});
      chk("R4 extPending", {31'h0, extPending}, {31'h0, |act2});
      chk("R7 irqTake", {31'h0, irqTake}, {31'h0, |act2});
      if (act2 == 0) chk("R6 idle index", {27'h0, lowestIdx}, 32'h0);
    end

    // R3 latency: one edge is not enough, two edges are
    apply(32'h0, 32'hFFFF_FFFF);
    irqIn = 32'h0000_0400;
    @(negedge clk);
    rdCsr(12'hFE0, d); chk("R3 after one edge", d, 32'h0);
    @(negedge clk);
    rdCsr(12'hFE0, d); chk("R3 after two edges", d, 32'h0000_0400);
    irqIn = 32'h0;
    @(negedge clk);
    rdCsr(12'hFE0, d); chk("R3 fall one edge", d, 32'h0000_0400);
    @(negedge clk);
    rdCsr(12'hFE0, d); chk("R3 fall two edges", d, 32'h0);

    // Same-edge collision: pending rise and mask write on one edge (R2, R5)
    apply(32'h0000_0002, 32'hFFFF_FFFD); // line 1 pending but masked
    irqIn = 32'h0000_0022;               // line 5 rises
    @(negedge clk);                      // line 5 in first flop
    csrAddr = 12'hBE0; csrWrEn = 1'b1; csrWrData = 32'h0000_0002;
    #1;
    chk("R2 read during write", csrRdData, 32'hFFFF_FFFD);
    chk("R5 before collision", {27'h0, lowestIdx}, 32'h0);
    chk("R4 before collision", {31'h0, extPending}, 32'h0);
    @(negedge clk);
    csrWrEn = 1'b0;
    chk("R5 after collision", {27'h0, lowestIdx}, 32'd1);
    rdCsr(12'hFE0, d); chk("R3 collision pending", d, 32'h0000_0022);
    chk("R4 after collision", {31'h0, extPending}, 32'h1);

    // R7 gating by the global enables
    globalIe = 1'b0; #1;
    chk("R7 globalIe low", {31'h0, irqTake}, 32'h0);
    globalIe = 1'b1; extIe = 1'b0; #1;
    chk("R7 extIe low", {31'h0, irqTake}, 32'h0);
    extIe = 1'b1; #1;
    chk("R7 both high", {31'h0, irqTake}, 32'h1);

    // R8 reserved and unmapped reads
    foreach (VEC[n]) begin end
    rdCsr(12'hBE1, d); chk("R8 read BE1", d, 32'h0);
    rdCsr(12'hBE3, d); chk("R8 read BE3", d, 32'h0);
    rdCsr(12'hFE1, d); chk("R8 read FE1", d, 32'h0);
    rdCsr(12'hFE3, d); chk("R8 read FE3", d, 32'h0);
    rdCsr(12'h300, d); chk("R8 read unmapped", d, 32'h0);

    // R9 and R10: writes elsewhere do not touch the enable or pending CSRs
    @(negedge clk);
    csrWrEn = 1'b1; csrWrData = 32'hFFFF_FFFF;
    csrAddr = 12'hFE0; @(negedge clk);
    csrAddr = 12'hFE4; @(negedge clk);
    csrAddr = 12'hBE2; @(negedge clk);
    csrAddr = 12'h7C0; @(negedge clk);
    csrWrEn = 1'b0;
    rdCsr(12'hBE0, d); chk("R9 enable unchanged", d, 32'h0000_0002);
    rdCsr(12'hFE0, act); chk("R10 pending unchanged", act, 32'h0000_0022);
    rdCsr(12'hFE4, d); chk("R5 lowest after ro writes", d, 32'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule